// File: doc/BRIEF.md
# Burst Address Generator with Recall

This block produces the address for each access on one port of a synchronous memory. On every rising clock edge it settles on one of four sources: the address presented on its input, its own stored address plus one, its own stored address unchanged, or an address it saved earlier. The chosen address leaves the block combinationally, so the memory can use it on the same edge that stores it as the new internal address.

The saved address is captured each time an external address is actually loaded. Asserting the recall input later brings that address back in a single cycle, so a burst can be restarted without the host presenting the address again. The block has no chip-select or byte-select input. Its controls act on every edge, and a burst keeps counting while the memory it feeds is deselected.

Top module: `burst_addr_gen`

## Requirements
- R1: With `load`=1 and `recall`=0, `addr_out` equals `ext_addr` in that cycle, whatever the value of `count`, and the internal address takes that value at the edge.
- R2: With `recall`=0, `load`=0 and `count`=1, `addr_out` equals the internal address plus one, and the internal address takes that value at the edge.
- R3: With `recall`, `load` and `count` all 0, `addr_out` equals the internal address, which stays unchanged; `ext_addr` has no effect.
- R4: With `recall`=1, `addr_out` equals the saved repeat address and becomes the internal address, whatever `load`, `count` and `ext_addr` are. Recall takes priority over load, and load over increment.
- R5: The repeat address is replaced by `ext_addr` on every edge where the R1 case applies, and on no other edge. A `load` that arrives together with `recall` does not replace it.
- R6: Incrementing from the all-ones address gives zero, for any `ADDR_W`.
- R7: A synchronous reset (`rst`=1 at an edge) clears the internal address to zero. The repeat address is left unset when `RPT_CLEAR`=0 and cleared to zero when `RPT_CLEAR`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ext_addr | input | ADDR_W | Externally supplied address |
| load | input | 1 | Use `ext_addr` and save it as the repeat address (active high) |
| count | input | 1 | Advance the internal address by one (active high) |
| recall | input | 1 | Return to the saved repeat address (active high, highest priority) |
| addr_out | output | ADDR_W | Address used for the current access |

## Verification
The recall assertion compares against the stored repeat address. It therefore assumes that no recall comes before the first load after power-up, unless `RPT_CLEAR` is set. The bench sets `RPT_CLEAR`=1 and resets first, so the repeat address holds a known zero from the start. The inputs change only at the falling edge, so the controls are stable at each rising edge. A four-bit configuration is swept through every control combination against many input addresses and starting states, and wrap-around occurs many times.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    // Source of the address used in a cycle
    typedef enum logic [1:0] {
        SRC_HOLD   = 2'd0,
        SRC_INC    = 2'd1,
        SRC_LOAD   = 2'd2,
        SRC_RECALL = 2'd3
    } addr_src_e;

    // Decoded control for one cycle
    typedef struct packed {
        addr_src_e src;
        logic      capture;
    } addr_ctl_t;

    // Priority: recall, then load, then count, then hold
    function automatic addr_src_e pick_src(input logic recall,
                                           input logic load,
                                           input logic count);
        if (recall)     return SRC_RECALL;
        else if (load)  return SRC_LOAD;
        else if (count) return SRC_INC;
        else            return SRC_HOLD;
    endfunction

endpackage

// File: rtl/bac_ctrl.sv
module bac_ctrl
    import burst_addr_pkg::*;
(
    input  logic      load,
    input  logic      count,
    input  logic      recall,
    output addr_ctl_t ctl
);
    always_comb begin
        ctl.src     = pick_src(recall, load, count);
        ctl.capture = (ctl.src == SRC_LOAD);
    end
endmodule

// File: rtl/bac_repeat.sv
module bac_repeat #(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              capture,
    input  logic [ADDR_W-1:0] d,
    output logic [ADDR_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (clr)          q <= '0;
        else if (capture) q <= d;
    end
endmodule

// File: rtl/bac_counter.sv
module bac_counter
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  addr_src_e         src,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic [ADDR_W-1:0] rpt_addr,
    output logic [ADDR_W-1:0] eff_addr,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam logic [ADDR_W-1:0] ONE     = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ALL_ONE = '1;

    logic [ADDR_W-1:0] inc_addr;
    assign inc_addr = cur_addr + ONE;   // width-truncated, wraps to zero

    always_comb begin
        unique case (src)
            SRC_RECALL: eff_addr = rpt_addr;
            SRC_LOAD:   eff_addr = ext_addr;
            SRC_INC:    eff_addr = inc_addr;
            default:    eff_addr = cur_addr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cur_addr <= '0;
        else     cur_addr <= eff_addr;
    end

    // R6: wrap from all ones
    p_wrap_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_INC && cur_addr == ALL_ONE) |=> (cur_addr == '0));

    // R7: reset clears the internal address
    p_reset_clear_r7: assert property (@(posedge clk)
        rst |=> (cur_addr == '0));
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter bit RPT_CLEAR = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              load,
    input  logic              count,
    input  logic              recall,
    output logic [ADDR_W-1:0] addr_out
);
    addr_ctl_t         ctl;
    logic              rpt_clr;
    logic [ADDR_W-1:0] rpt_q;
    logic [ADDR_W-1:0] cur_q;

    generate
        if (RPT_CLEAR) begin : g_rpt_clear
            assign rpt_clr = rst;
        end else begin : g_rpt_keep
            assign rpt_clr = 1'b0;
        end
    endgenerate

    bac_ctrl u_ctrl (
        .load   (load),
        .count  (count),
        .recall (recall),
        .ctl    (ctl)
    );

    bac_repeat #(.ADDR_W(ADDR_W)) u_rpt (
        .clk     (clk),
        .clr     (rpt_clr),
        .capture (ctl.capture),
        .d       (ext_addr),
        .q       (rpt_q)
    );

    bac_counter #(.ADDR_W(ADDR_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .src      (ctl.src),
        .ext_addr (ext_addr),
        .rpt_addr (rpt_q),
        .eff_addr (addr_out),
        .cur_addr (cur_q)
    );

    // R1: a load without recall becomes the internal address
    p_load_takes_r1: assert property (@(posedge clk) disable iff (rst)
        (load && !recall) |=> (cur_q == $past(ext_addr)));

    // R2: a count alone advances by one
    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!recall && !load && count) |=> (cur_q == $past(cur_q) + ADDR_W'(1)));

    // R3: no control leaves the address alone
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!recall && !load && !count) |=> $stable(cur_q));

    // R4: recall restores the saved address
    p_recall_back_r4: assert property (@(posedge clk) disable iff (rst)
        recall |=> (cur_q == $past(rpt_q)));

    // R5: the saved address changes only on an effective load
    p_rpt_capture_r5: assert property (@(posedge clk) disable iff (rst)
        (load && !recall) |=> (rpt_q == $past(ext_addr)));
    p_rpt_keep_r5: assert property (@(posedge clk) disable iff (rst)
        !(load && !recall) |=> $stable(rpt_q));
endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
    localparam int AW = 4;
    localparam int MOD = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] ext_addr = '0;
    logic          load = 1'b0;
    logic          count = 1'b0;
    logic          recall = 1'b0;
    logic [AW-1:0] addr_out;

    int n_chk = 0;
    int n_bad = 0;
    int m_cur = 0;
    int m_rpt = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    burst_addr_gen #(.ADDR_W(AW), .RPT_CLEAR(1'b1)) uut (
        .clk(clk), .rst(rst), .ext_addr(ext_addr), .load(load),
        .count(count), .recall(recall), .addr_out(addr_out)
    );

    task automatic check(input string req, input int exp);
        n_chk++;
        if (int'(addr_out) != exp) begin
            n_bad++;
            $display("FAIL %s addr_out=%0d expected=%0d", req, addr_out, exp);
        end
    endtask

    // Drive one cycle at the falling edge, check the address, update the model
    task automatic step(input bit rc, input bit ld, input bit ct, input int e);
        int    exp;
        string req;
        @(negedge clk);
        recall = rc; load = ld; count = ct; ext_addr = AW'(e);
        #1;
        if (rc)      begin exp = m_rpt;             req = "R4"; end
        else if (ld) begin exp = e;                 req = "R1"; end
        else if (ct) begin exp = (m_cur + 1) % MOD; req = (m_cur == MOD-1) ? "R6" : "R2"; end
        else         begin exp = m_cur;             req = "R3"; end
        check(req, exp);
        if (ld && !rc) m_rpt = e;   // R5
        m_cur = exp;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; load = 1'b0; count = 1'b0; recall = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        m_cur = 0; m_rpt = 0;
    endtask

    initial begin
        #150000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        // R7: reset state, internal and repeat addresses both zero
        #1 check("R7", 0);
        step(1, 0, 0, 9);    // recall right after reset yields zero (R7)
        // R1: load with count also set; count ignored
        step(0, 1, 1, 5);
        step(0, 0, 0, 11);   // R3: hold, ext ignored
        // R6: count up through the wrap
        for (int i = 0; i < 20; i++) step(0, 0, 1, i);
        // R4/R5: recall with load and count set must not replace the repeat address
        step(1, 1, 1, 2);
        step(0, 0, 1, 0);
        step(1, 0, 0, 7);
        // R7: reset mid-run
        step(0, 1, 0, 13);
        do_reset();
        #1 check("R7", 0);
        // Sweep: every control combination against many addresses and states
        for (int n = 0; n < 4096; n++) begin
            int c;
            c = (n ^ (n >> 3) ^ (n >> 6)) & 7;
            step(c[2], c[1], c[0], (n * 7 + (n >> 4)) % MOD);
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule